// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 1M words by 32 bits. The RAM is split into four byte lanes, and each lane has its own active-low chip enable. The RAM also has one shared active-low write strobe, one shared active-low output enable, a 20-bit address and a shared bidirectional 32-bit data bus. A client issues one read or one write at a time, together with a four-bit lane mask. Only the masked lanes take part in the access, so any mix of bytes can be read or written.

The controller turns each request into a short sequence of pin phases. Every phase length is a count of controller clocks. These counts are derived at elaboration from timing figures given in picoseconds, rounded up to whole clocks, so that the read cycle, address access, output-enable access, write pulse, data setup, address-to-end-of-write and write cycle limits are all met. The default grade is 12 ns reads and 15 ns writes at a 100 MHz clock.

Before any write, the controller holds the RAM's output enable high for at least one clock. It drives the bus only while the write strobe is low, plus one clock of hold afterwards. This keeps the two bus drivers apart. Read data comes back with a one-clock valid pulse, and lanes outside the mask read as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and directly after reset, `req_ready` is 1. All four `sram_ce_n` bits, `sram_we_n` and `sram_oe_n` are 1. The bus is not driven and `rd_valid` is 0.
- R2: An accepted read holds `sram_oe_n` at 0 and `sram_we_n` at 1 for the read count (2 clocks by default). During this time `sram_addr` equals the request address. `sram_ce_n[l]` is 0 exactly when `req_be[l]` is 1, where lane l is bits 8l+7 down to 8l.
- R3: The clock after the last read clock, the pins return to idle and `rd_valid` is 1 for exactly one clock. `rd_data` then holds the bus bytes of the masked lanes, with zero in the other lanes. `req_ready` is 1 in that same clock.
- R4: The first clock of an accepted write shows the address and the masked chip enables, with `sram_we_n` and `sram_oe_n` both 1 and the bus not driven by the controller.
- R5: The write pulse then holds `sram_we_n` at 0 for the pulse count (1 clock by default). During the pulse the controller drives `req_wdata` on `sram_dq`, and the address and chip enables stay unchanged.
- R6: After the pulse, one hold clock keeps `sram_we_n` at 1 with the data still driven, the chip enables still low and the address unchanged. The pins then return to idle.
- R7: A write keeps `req_ready` low for the pulse count plus two clocks (3 by default). That span is at least the write cycle time.
- R8: `req_ready` is 1 only when every pin is idle. A request presented while `req_ready` is 0 is ignored: the pin sequence is unchanged and the RAM contents are unchanged.
- R9: A read keeps `req_ready` low for the read count. That count is the largest of the rounded-up read cycle time, address access time and output-enable access time.
- R10: `sram_oe_n` and `sram_we_n` are never both 0, and the controller drives the bus only while `sram_oe_n` is 1.
- R11: A request with an all-zero lane mask still runs its full sequence. A write with this mask changes no byte of the RAM, and a read with this mask returns zero with a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Word address |
| req_be | input | 4 | Lane mask, bit l selects bits 8l+7:8l |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle and able to take a request |
| rd_valid | output | 1 | One-clock read data strobe |
| rd_data | output | 32 | Captured read word, unmasked lanes zero |
| sram_addr | output | 20 | RAM address |
| sram_ce_n | output | 4 | Per-lane active-low chip enables |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq | inout | 32 | Shared data bus |

## Verification
A sequencer stuck in a wrong phase, or a counter loaded with a wrong length, shows up at the pins within one clock. The strobes rise or fall a clock early or late, `req_ready` comes back at the wrong time, or `rd_valid` moves. The bench compares every pin with a per-clock expected frame, so such faults are caught on the first bad clock. A wrong lane mask, wrong data drive or wrong capture is silent at the pins during the write itself. It appears at the next read of that address, because the bench RAM model stores only what the pins actually wrote. Requests made while the controller is busy are followed by readbacks, so an accepted stray write would show up as altered data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD
    } phase_e;

    // Whole clocks needed to cover a duration, rounded up.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Clocks by which a figure exceeds a span of 'covered' clocks already spent.
    function automatic int unsigned excess_u(input int unsigned need, input int unsigned covered);
        return (need > covered) ? (need - covered) : 0;
    endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned RD_CYC = 2,
    parameter int unsigned WP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [LANES-1:0]  ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              bus_drive,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              rd_capture,
    output logic [LANES-1:0]  rd_lanes
);

    localparam int unsigned MAX_CYC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  ce_n;
        logic              we_n;
        logic              oe_n;
        logic              drive;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.ce_n  = ~req_be;
                    seq_d.wdata = req_wdata;
                    if (req_write) begin
                        seq_d.phase = PH_WSETUP;
                    end else begin
                        seq_d.phase = PH_READ;
                        seq_d.cnt   = CW'(RD_CYC - 1);
                        seq_d.oe_n  = 1'b0;
                    end
                end
            end
            PH_READ: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.ce_n  = '1;
                    seq_d.oe_n  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_WSETUP: begin
                seq_d.phase = PH_WPULSE;
                seq_d.cnt   = CW'(WP_CYC - 1);
                seq_d.we_n  = 1'b0;
                seq_d.drive = 1'b1;
            end
            PH_WPULSE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_WHOLD;
                    seq_d.we_n  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_WHOLD: begin
                seq_d.phase = PH_IDLE;
                seq_d.ce_n  = '1;
                seq_d.drive = 1'b0;
            end
            default: begin
                seq_d.phase = PH_IDLE;
                seq_d.ce_n  = '1;
                seq_d.we_n  = 1'b1;
                seq_d.oe_n  = 1'b1;
                seq_d.drive = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.cnt   <= '0;
            seq_q.addr  <= '0;
            seq_q.ce_n  <= '1;
            seq_q.we_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
            seq_q.drive <= 1'b0;
            seq_q.wdata <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready      = (seq_q.phase == PH_IDLE);
    assign rd_capture = (seq_q.phase == PH_READ) && (seq_q.cnt == '0);
    assign rd_lanes   = ~seq_q.ce_n;
    assign ram_addr   = seq_q.addr;
    assign ram_ce_n   = seq_q.ce_n;
    assign ram_we_n   = seq_q.we_n;
    assign ram_oe_n   = seq_q.oe_n;
    assign bus_drive  = seq_q.drive;
    assign bus_wdata  = seq_q.wdata;

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [DATA_W-1:0] masked;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign masked[l*LANE_W +: LANE_W] = lane_en[l] ? bus_in[l*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = capture;
        if (capture) begin
            cap_d.data = masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.valid <= 1'b0;
            cap_q.data  <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_valid = cap_q.valid;
    assign rd_data  = cap_q.data;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned LANES   = 4,
    parameter int unsigned CLK_PS  = 10000,
    parameter int unsigned T_RC_PS = 12000,
    parameter int unsigned T_AA_PS = 12000,
    parameter int unsigned T_OE_PS = 6000,
    parameter int unsigned T_WC_PS = 15000,
    parameter int unsigned T_WP_PS = 10000,
    parameter int unsigned T_AW_PS = 10000,
    parameter int unsigned T_DW_PS = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [LANES-1:0]  sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq
);

    // Read: address, cycle and output-enable access all end at the capture edge.
    localparam int unsigned RD_CYC = max_u(1, max_u(max_u(ceil_div(T_RC_PS, CLK_PS),
                                                          ceil_div(T_AA_PS, CLK_PS)),
                                                    ceil_div(T_OE_PS, CLK_PS)));
    // Write: setup and hold clocks add to the pulse for cycle time; setup adds for address.
    localparam int unsigned WP_CYC = max_u(1, max_u(max_u(ceil_div(T_WP_PS, CLK_PS),
                                                          ceil_div(T_DW_PS, CLK_PS)),
                                                    max_u(excess_u(ceil_div(T_WC_PS, CLK_PS), 2),
                                                          excess_u(ceil_div(T_AW_PS, CLK_PS), 1))));

    logic              dq_drive;
    logic [DATA_W-1:0] dq_wdata;
    logic              rd_capture;
    logic [LANES-1:0]  rd_lanes;

    sram_lane_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .ready      (req_ready),
        .ram_addr   (sram_addr),
        .ram_ce_n   (sram_ce_n),
        .ram_we_n   (sram_we_n),
        .ram_oe_n   (sram_oe_n),
        .bus_drive  (dq_drive),
        .bus_wdata  (dq_wdata),
        .rd_capture (rd_capture),
        .rd_lanes   (rd_lanes)
    );

    sram_lane_capture #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .lane_en  (rd_lanes),
        .bus_in   (sram_dq),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign sram_dq = dq_drive ? dq_wdata : 'z;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [LANES-1:0]  sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              dq_drive
);

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    assert_drive_oe_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> sram_oe_n);

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((&sram_ce_n) && sram_we_n && sram_oe_n && !dq_drive));

    assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!sram_oe_n));

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n && $past(!sram_oe_n)) |-> ($stable(sram_addr) && $stable(sram_ce_n)));

    assert_we_fall_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_oe_n) && $stable(sram_addr) && $stable(sram_ce_n)));

    assert_we_rise_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (dq_drive && $stable(sram_addr) && $stable(sram_ce_n)));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .dq_drive  (dq_drive)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;

    localparam int CLK_PS  = 10000;
    localparam int T_RC_PS = 12000;
    localparam int T_AA_PS = 12000;
    localparam int T_OE_PS = 6000;
    localparam int T_WC_PS = 15000;
    localparam int T_WP_PS = 10000;
    localparam int T_AW_PS = 10000;
    localparam int T_DW_PS = 7000;
    // R9: read length is the largest rounded-up read figure (2 at defaults)
    localparam int RD_N = 2;
    // Write pulse covers pulse width and data setup (1 at defaults)
    localparam int WP_N = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [19:0] sram_addr;
    logic [3:0]  sram_ce_n;
    logic        sram_we_n;
    logic        sram_oe_n;
    wire  [31:0] sram_dq;

    always #5 clk = ~clk;

    sram_lane_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .sram_addr (sram_addr),
        .sram_ce_n (sram_ce_n),
        .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n),
        .sram_dq   (sram_dq)
    );

    // Behavioural RAM: stores only what the pins write.
    logic [31:0] ram_arr [logic [19:0]];
    logic [31:0] ram_word;

    function automatic logic [31:0] ram_peek(input logic [19:0] a);
        return ram_arr.exists(a) ? ram_arr[a] : 32'h0;
    endfunction

    always @(sram_addr or sram_we_n) ram_word = ram_peek(sram_addr);

    for (genvar l = 0; l < 4; l++) begin : g_ram_lane
        assign sram_dq[l*8 +: 8] = (!sram_ce_n[l] && sram_we_n && !sram_oe_n) ? ram_word[l*8 +: 8] : 8'hzz;
    end

    always @(posedge sram_we_n) begin
        if (rst_n) begin
            logic [31:0] w;
            w = ram_peek(sram_addr);
            for (int l = 0; l < 4; l++)
                if (!sram_ce_n[l]) w[l*8 +: 8] = sram_dq[l*8 +: 8];
            ram_arr[sram_addr] = w;
        end
    end

    // Reference model: expected pin frame per clock.
    typedef struct {
        logic [3:0]  ce;
        logic        we;
        logic        oe;
        logic        rdy;
        logic        rv;
        logic [31:0] rd;
        logic        chk_a;
        logic [19:0] addr;
        logic        chk_d;
        logic [31:0] dq;
        string       tag;
    } frame_t;

    frame_t      exp_q[$];
    logic [31:0] ref_mem [logic [19:0]];
    logic        cur_rdy = 1'b1;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;

    function automatic frame_t idle_frame();
        frame_t f;
        f.ce = 4'hF; f.we = 1'b1; f.oe = 1'b1; f.rdy = 1'b1; f.rv = 1'b0; f.rd = '0;
        f.chk_a = 1'b0; f.addr = '0; f.chk_d = 1'b0; f.dq = '0; f.tag = "R8";
        return f;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{be[l]}};
        return m;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_frame();
        frame_t f;
        f = (exp_q.size() != 0) ? exp_q.pop_front() : idle_frame();
        cur_rdy = f.rdy;
        chk(f.tag, "ready", {31'b0, req_ready}, {31'b0, f.rdy});
        chk(f.tag, "ce_n", {28'b0, sram_ce_n}, {28'b0, f.ce});
        chk(f.tag, "we_n", {31'b0, sram_we_n}, {31'b0, f.we});
        chk(f.tag, "oe_n", {31'b0, sram_oe_n}, {31'b0, f.oe});
        chk(f.tag, "rd_valid", {31'b0, rd_valid}, {31'b0, f.rv});
        if (f.rv)    chk(f.tag, "rd_data", rd_data, f.rd);
        if (f.chk_a) chk(f.tag, "addr", {12'b0, sram_addr}, {12'b0, f.addr});
        if (f.chk_d) chk(f.tag, "dq", sram_dq, f.dq);
    endtask

    task automatic push_frames(input logic wr, input logic [19:0] a, input logic [3:0] be,
                               input logic [31:0] d, input string rtag);
        frame_t f;
        logic [31:0] old;
        f = idle_frame();
        f.rdy = 1'b0; f.ce = ~be; f.chk_a = 1'b1; f.addr = a;
        old = ref_mem.exists(a) ? ref_mem[a] : 32'h0;
        if (!wr) begin
            f.oe = 1'b0; f.tag = "R2";
            for (int i = 0; i < RD_N; i++) exp_q.push_back(f);
            f = idle_frame();
            f.rv = 1'b1; f.rd = old & lane_mask(be); f.tag = rtag;
            exp_q.push_back(f);
        end else begin
            f.tag = "R4";
            exp_q.push_back(f);
            f.we = 1'b0; f.chk_d = 1'b1; f.dq = d; f.tag = "R5";
            for (int i = 0; i < WP_N; i++) exp_q.push_back(f);
            f.we = 1'b1; f.tag = "R6";
            exp_q.push_back(f);
            ref_mem[a] = (old & ~lane_mask(be)) | (d & lane_mask(be));
        end
    endtask

    task automatic cycle(input logic v, input logic wr, input logic [19:0] a, input logic [3:0] be,
                         input logic [31:0] d, input string rtag);
        @(negedge clk);
        check_frame();
        req_valid = v; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        if (v && cur_rdy) push_frames(wr, a, be, d, rtag);
    endtask

    // Issue one request when idle and measure how long ready stays low.
    task automatic run_op(input logic wr, input logic [19:0] a, input logic [3:0] be,
                          input logic [31:0] d, input string rtag);
        int n;
        cycle(1'b1, wr, a, be, d, rtag);
        n = 0;
        do begin
            cycle(1'b0, 1'b0, '0, '0, '0, "R3");
            n++;
        end while (!cur_rdy);
        if (wr) begin
            chk("R7", "write busy clocks", n - 1, WP_N + 2);
            chk("R7", "write span covers cycle time", ((n - 1) * CLK_PS >= T_WC_PS), 1);
            chk("R5", "pulse covers width and setup",
                (WP_N * CLK_PS >= T_WP_PS) && (WP_N * CLK_PS >= T_DW_PS) && ((WP_N + 1) * CLK_PS >= T_AW_PS), 1);
        end else begin
            chk("R9", "read busy clocks", n - 1, RD_N);
            chk("R9", "read span covers access",
                ((n - 1) * CLK_PS >= T_RC_PS) && ((n - 1) * CLK_PS >= T_AA_PS) && ((n - 1) * CLK_PS >= T_OE_PS), 1);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk("R1", "ready in reset", {31'b0, req_ready}, 1);
        chk("R1", "ce_n in reset", {28'b0, sram_ce_n}, 32'hF);
        chk("R1", "strobes in reset", {30'b0, sram_we_n, sram_oe_n}, 3);
        chk("R1", "rd_valid in reset", {31'b0, rd_valid}, 0);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, '0, '0, '0, "R1");

        run_op(1'b1, 20'h00001, 4'hF, 32'hA5A5_1234, "R3");
        run_op(1'b0, 20'h00001, 4'hF, '0, "R3");
        run_op(1'b1, 20'hFFFFF, 4'b0101, 32'h1122_3344, "R3");
        run_op(1'b0, 20'hFFFFF, 4'hF, '0, "R3");
        run_op(1'b0, 20'h00001, 4'b1010, '0, "R3");

        // R8: requests while busy are ignored
        cycle(1'b1, 1'b1, 20'h00002, 4'hF, 32'h0BAD_F00D, "R3");
        for (int i = 0; i < WP_N + 2; i++) cycle(1'b1, 1'b1, 20'h00001, 4'hF, 32'hDEAD_BEEF, "R8");
        cycle(1'b0, 1'b0, '0, '0, '0, "R8");
        cycle(1'b1, 1'b0, 20'h00002, 4'hF, '0, "R3");
        for (int i = 0; i < RD_N; i++) cycle(1'b1, 1'b1, 20'h00001, 4'hF, 32'hDEAD_BEEF, "R8");
        cycle(1'b0, 1'b0, '0, '0, '0, "R8");
        run_op(1'b0, 20'h00001, 4'hF, '0, "R8");

        // R11: all-zero lane mask
        run_op(1'b1, 20'h00001, 4'h0, 32'hFFFF_FFFF, "R11");
        run_op(1'b0, 20'h00001, 4'hF, '0, "R11");
        run_op(1'b0, 20'h00001, 4'h0, '0, "R11");

        // Back-to-back mixed traffic over a small address window
        for (int i = 0; i < 40; i++) begin
            run_op(1'($urandom % 2), 20'($urandom % 8), 4'($urandom % 16), $urandom, "R3");
        end
        for (int a = 0; a < 8; a++) run_op(1'b0, 20'(a), 4'hF, '0, "R3");

        repeat (3) cycle(1'b0, 1'b0, '0, '0, '0, "R8");
        done = 1;
        summary();
        $finish;
    end

endmodule